// File: doc/BRIEF.md
# Watermark-Paced Block DMA Channel

This block is one direction-selectable DMA channel that sits between a word FIFO and a memory port. Software programs a start address, a number of blocks and a direction, then sets an enable bit. From that moment the channel works on private copies of those settings. Each time the FIFO's level flag asks for service, it moves one fixed-size block of words. In the memory-to-FIFO direction it waits for the programmable-empty flag, reads memory and pushes each word into the FIFO. In the FIFO-to-memory direction it waits for the programmable-full flag, pops each word and writes it to memory.

Memory accesses use a plain request/acknowledge handshake, one word per access. The address steps by one 32-bit bus word for each word moved and carries on across block boundaries. A done flag rises after the last word of the last block. Clearing the enable bit stops the channel once the word in flight has finished.

Top module: `blkdma_chan`

## Requirements
- R1: After reset, all four registers read zero, `done` is 0, and `mem_req`, `fifo_push` and `fifo_pop` are low.
- R2: Register select 0 is control: bit 31 is enable, bit 0 is direction (1 = memory to FIFO, 0 = FIFO to memory), and all other bits read 0. Select 1 is the 32-bit start address and reads back as written. Select 2 holds the block count in bits 31:8, and bits 7:0 read 0. Select 3 is read-only status: bit 0 is done, bit 1 is busy (waiting for a block or moving one), and writes to it are ignored.
- R3: The address, the count and the direction are copied when an enabled channel leaves idle. Writes to the address, count or direction registers during a transfer do not change that transfer.
- R4: A block starts only while the flag for the latched direction is high: programmable-empty for memory to FIFO, programmable-full for FIFO to memory. While that flag is low, no memory request is made.
- R5: A started block moves exactly 16 words without looking at the flag again.
- R6: The first word uses the start address with bits 1:0 cleared. Each following word adds 4, and this continues across blocks.
- R7: `mem_req` stays high with a stable address and write flag until `mem_ack`. A word completes in the cycle in which both are high. `mem_we` is 0 for memory reads and 1 for memory writes.
- R8: Memory to FIFO: each word is a read, and `fifo_push` is high with `fifo_wdata` equal to `mem_rdata` in the acknowledge cycle.
- R9: FIFO to memory: each word is a write of `fifo_rdata` (show-ahead FIFO), and `fifo_pop` is high in the acknowledge cycle.
- R10: `done` is cleared when a transfer starts and stays 0 while it runs. It is set after the last word of the last block and holds, including after a disable, until the next start. A count of 0 sets `done` with no memory access.
- R11: Clearing enable during a transfer completes the word in flight, after which the channel goes idle with busy 0 and `done` 0. Enabling again restarts from the register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| fifo_prog_empty | input | 1 | FIFO below its low watermark |
| fifo_prog_full | input | 1 | FIFO above its high watermark |
| fifo_push | output | 1 | Push `fifo_wdata` into the FIFO |
| fifo_wdata | output | DATA_W | Word pushed into the FIFO |
| fifo_pop | output | 1 | Pop the head word of the FIFO |
| fifo_rdata | input | DATA_W | Head word of the FIFO (show-ahead) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| done | output | 1 | All blocks finished |

## Verification
A wrong working address shows on `mem_addr` at the very next acknowledged word. Every word's address and data are compared with an arithmetic expectation, so such an error is caught at once. A word counter that is off, or a block counter that is off, changes how many words come before `done`, or how many arrive after the flag drops between blocks. Either one appears at the end of a block. A wrong latched direction or a wrong watermark choice shows up before the first word, either as the wrong `mem_we` or as a channel that never requests.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_BASE  = 2'd1,
      SEL_COUNT = 2'd2,
      SEL_STAT  = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_MOVE = 2'd2,
      ST_FIN  = 2'd3
   } seq_st_e;

   localparam int unsigned REG_W   = 32;
   localparam int unsigned ENA_BIT = 31;
   localparam int unsigned DIR_BIT = 0;
   localparam int unsigned CNT_LSB = 8;
endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
   import blkdma_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic              stat_done,
   input  logic              stat_busy,
   output logic              cfg_en,
   output logic              cfg_dir,
   output logic [REG_W-1:0]  cfg_base,
   output logic [CNT_W-1:0]  cfg_cnt
);
   localparam int unsigned PAD_W = REG_W - CNT_W;

   if (CNT_W + CNT_LSB != REG_W) begin : g_bad_cnt
      $error("blkdma_regs: count field must fill bits above CNT_LSB");
   end

   reg_sel_e sel_e;
   assign sel_e = reg_sel_e'(sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en   <= 1'b0;
         cfg_dir  <= 1'b0;
         cfg_base <= '0;
         cfg_cnt  <= '0;
      end else if (we) begin
         case (sel_e)
            SEL_CTRL: begin
               cfg_en  <= wdata[ENA_BIT];
               cfg_dir <= wdata[DIR_BIT];
            end
            SEL_BASE:  cfg_base <= wdata;
            SEL_COUNT: cfg_cnt  <= wdata[REG_W-1:CNT_LSB];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (sel_e)
         SEL_CTRL: begin
            rdata[ENA_BIT] = cfg_en;
            rdata[DIR_BIT] = cfg_dir;
         end
         SEL_BASE:  rdata = cfg_base;
         SEL_COUNT: rdata = {cfg_cnt, {PAD_W{1'b0}}};
         SEL_STAT:  rdata = {{(REG_W-2){1'b0}}, stat_busy, stat_done};
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
   import blkdma_pkg::*;
#(
   parameter int unsigned BLK_WORDS = 16,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned ADDR_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              dir_cfg,
   input  logic [REG_W-1:0]  base_cfg,
   input  logic [CNT_W-1:0]  cnt_cfg,
   input  logic              wm_empty,
   input  logic              wm_full,
   input  logic              ack,
   output logic              moving,
   output logic              xfer_dir,
   output logic [REG_W-1:0]  work_addr,
   output logic              done,
   output logic              busy
);
   localparam int unsigned IDX_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_WORDS - 1);
   localparam logic [CNT_W-1:0] ONE_BLK  = CNT_W'(1);
   localparam logic [REG_W-1:0] ALIGN_MASK = ~(REG_W'(ADDR_STEP) - REG_W'(1));

   if ((ADDR_STEP & (ADDR_STEP - 1)) != 0) begin : g_bad_step
      $error("blkdma_seq: ADDR_STEP must be a power of two");
   end

   seq_st_e          st;
   logic [CNT_W-1:0] w_cnt;
   logic [IDX_W-1:0] w_idx;
   logic             wmark;
   logic             last_word;
   logic             last_blk;

   assign wmark     = xfer_dir ? wm_empty : wm_full;
   assign last_word = (w_idx == LAST_IDX);
   assign last_blk  = (w_cnt == ONE_BLK);
   assign moving    = (st == ST_MOVE);
   assign busy      = (st == ST_WAIT) || (st == ST_MOVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         w_cnt     <= '0;
         w_idx     <= '0;
         work_addr <= '0;
         xfer_dir  <= 1'b0;
         done      <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (en) begin
                  work_addr <= base_cfg & ALIGN_MASK;
                  w_cnt     <= cnt_cfg;
                  xfer_dir  <= dir_cfg;
                  w_idx     <= '0;
                  done      <= (cnt_cfg == '0);
                  st        <= (cnt_cfg == '0) ? ST_FIN : ST_WAIT;
               end
            end
            ST_WAIT: begin
               w_idx <= '0;
               if (!en)        st <= ST_IDLE;
               else if (wmark) st <= ST_MOVE;
            end
            ST_MOVE: begin
               if (ack) begin
                  work_addr <= work_addr + REG_W'(ADDR_STEP);
                  w_idx     <= w_idx + IDX_W'(1);
                  if (last_word) begin
                     w_cnt <= w_cnt - ONE_BLK;
                     if (last_blk) begin
                        st   <= ST_FIN;
                        done <= 1'b1;
                     end else begin
                        st <= en ? ST_WAIT : ST_IDLE;
                     end
                  end else if (!en) begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_FIN: begin
               if (!en) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/blkdma_chan.sv
module blkdma_chan
   import blkdma_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BLK_WORDS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              fifo_prog_empty,
   input  logic              fifo_prog_full,
   output logic              fifo_push,
   output logic [DATA_W-1:0] fifo_wdata,
   output logic              fifo_pop,
   input  logic [DATA_W-1:0] fifo_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              done
);
   localparam int unsigned CNT_W     = REG_W - CNT_LSB;
   localparam int unsigned ADDR_STEP = 4;

   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_width
      $error("blkdma_chan: DATA_W must lie in 8..32");
   end
   if (BLK_WORDS < 2 || (BLK_WORDS & (BLK_WORDS - 1)) != 0) begin : g_bad_blk
      $error("blkdma_chan: BLK_WORDS must be a power of two of at least 2");
   end

   logic             en_w;
   logic             dir_w;
   logic [31:0]      base_w;
   logic [CNT_W-1:0] cnt_w;
   logic             moving;
   logic             xfer_dir;
   logic             busy;
   logic [31:0]      work_addr;

   blkdma_regs #(.CNT_W(CNT_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .sel       (reg_sel),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .stat_done (done),
      .stat_busy (busy),
      .cfg_en    (en_w),
      .cfg_dir   (dir_w),
      .cfg_base  (base_w),
      .cfg_cnt   (cnt_w)
   );

   blkdma_seq #(
      .BLK_WORDS (BLK_WORDS),
      .CNT_W     (CNT_W),
      .ADDR_STEP (ADDR_STEP)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_w),
      .dir_cfg   (dir_w),
      .base_cfg  (base_w),
      .cnt_cfg   (cnt_w),
      .wm_empty  (fifo_prog_empty),
      .wm_full   (fifo_prog_full),
      .ack       (mem_ack),
      .moving    (moving),
      .xfer_dir  (xfer_dir),
      .work_addr (work_addr),
      .done      (done),
      .busy      (busy)
   );

   // Data path: the FIFO head is wired straight through, with no staging register.
   assign mem_req    = moving;
   assign mem_we     = moving & ~xfer_dir;
   assign mem_addr   = work_addr;
   assign mem_wdata  = fifo_rdata;
   assign fifo_wdata = mem_rdata;
   assign fifo_push  = moving & mem_ack & xfer_dir;
   assign fifo_pop   = moving & mem_ack & ~xfer_dir;

   a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r6_step_per_word: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + 32'(ADDR_STEP)));

   a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   a_r8_push_on_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> mem_ack && !mem_we && !fifo_pop);

   a_r9_pop_on_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> mem_ack && mem_we && !fifo_push);

   a_r10_done_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req && !busy);

   a_r11_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !en_w && !mem_req |=> !mem_req);
endmodule

// File: tb/blkdma_chan_tb.sv
module blkdma_chan_tb_top;
   localparam int CLK_P = 10;
   localparam int DW    = 32;
   localparam int BLK   = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          fifo_prog_empty = 1'b0;
   logic          fifo_prog_full = 1'b0;
   logic          fifo_push;
   logic [DW-1:0] fifo_wdata;
   logic          fifo_pop;
   logic [DW-1:0] fifo_rdata = '0;
   logic          mem_req;
   logic          mem_we;
   logic [31:0]   mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ack = 1'b0;
   logic          done;

   int n_chk = 0;
   int n_fail = 0;
   int rec_idx = 0;
   int lat = 0;
   int wcnt = 0;
   int cyc = 0;
   logic [31:0] exp_base = '0;
   bit exp_dir = 1'b0;

   blkdma_chan #(.DATA_W(DW), .BLK_WORDS(BLK)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fifo_prog_empty(fifo_prog_empty), .fifo_prog_full(fifo_prog_full),
      .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done(done)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [31:0] memdata(input logic [31:0] a);
      return a ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] fifodata(input int i);
      return 32'hC000_0000 + 32'(i) * 32'd7;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // memory model: ack after lat idle cycles, one cycle long
   always @(negedge clk) begin
      cyc++;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
         if (wcnt >= lat) begin
            mem_ack   = 1'b1;
            mem_rdata = memdata(mem_addr);
            wcnt      = 0;
         end else wcnt++;
      end
   end

   // word monitor, a quarter period after the falling edge
   always @(negedge clk) begin
      #(CLK_P/4);
      if (mem_req && mem_ack) begin
         chk(mem_addr == exp_base + 32'(rec_idx) * 32'd4, "R6", "word address",
             mem_addr, exp_base + 32'(rec_idx) * 32'd4);
         chk(mem_we == !exp_dir, "R7", "write flag", {31'd0, mem_we}, {31'd0, !exp_dir});
         if (exp_dir) begin
            chk(fifo_push && !fifo_pop, "R8", "push strobe", {30'd0, fifo_push, fifo_pop}, 32'd2);
            chk(fifo_wdata == memdata(mem_addr), "R8", "pushed word", fifo_wdata, memdata(mem_addr));
         end else begin
            chk(fifo_pop && !fifo_push, "R9", "pop strobe", {30'd0, fifo_push, fifo_pop}, 32'd1);
            chk(mem_wdata == fifodata(rec_idx), "R9", "written word", mem_wdata, fifodata(rec_idx));
         end
         rec_idx++;
         fifo_rdata = fifodata(rec_idx);
      end
   end

   // watchdog
   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] s, output logic [31:0] d);
      @(negedge clk);
      reg_sel = s;
      #1;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_done(input int limit);
      for (int i = 0; i < limit && !done; i++) @(negedge clk);
   endtask

   task automatic wait_words(input int target, input int limit);
      for (int i = 0; i < limit && rec_idx < target; i++) @(negedge clk);
   endtask

   task automatic prep(input logic [31:0] base, input int nblk, input bit dir, input int l);
      reg_write(2'd1, base);
      reg_write(2'd2, 32'(nblk) << 8);
      exp_base = base & 32'hFFFF_FFFC;
      exp_dir = dir;
      lat = l;
      rec_idx = 0;
      fifo_rdata = fifodata(0);
   endtask

   logic [31:0] rd;

   initial begin
      idle(3);
      // R1: reset state
      chk(!mem_req && !fifo_push && !fifo_pop, "R1", "strobes in reset",
          {29'd0, mem_req, fifo_push, fifo_pop}, 32'd0);
      chk(done == 1'b0, "R1", "done in reset", {31'd0, done}, 32'd0);
      rst_n = 1'b1;
      for (int s = 0; s < 4; s++) begin
         reg_read(2'(s), rd);
         chk(rd == 32'd0, "R1", "register after reset", rd, 32'd0);
      end

      // R2: register map
      reg_write(2'd0, 32'h7FFF_FFFF);
      reg_read(2'd0, rd);
      chk(rd == 32'h0000_0001, "R2", "control readback", rd, 32'h0000_0001);
      reg_write(2'd1, 32'hDEAD_BEEF);
      reg_read(2'd1, rd);
      chk(rd == 32'hDEAD_BEEF, "R2", "address readback", rd, 32'hDEAD_BEEF);
      reg_write(2'd2, 32'hFFFF_FFFF);
      reg_read(2'd2, rd);
      chk(rd == 32'hFFFF_FF00, "R2", "count readback", rd, 32'hFFFF_FF00);
      reg_write(2'd3, 32'hFFFF_FFFF);
      reg_read(2'd3, rd);
      chk(rd == 32'd0, "R2", "status ignores writes", rd, 32'd0);
      reg_write(2'd0, 32'd0);

      // R10: zero count finishes at once
      fifo_prog_empty = 1'b1; fifo_prog_full = 1'b1;
      prep(32'h0000_0100, 0, 1'b1, 0);
      reg_write(2'd0, 32'h8000_0001);
      idle(3);
      chk(done == 1'b1, "R10", "zero-count done", {31'd0, done}, 32'd1);
      reg_read(2'd3, rd);
      chk(rd == 32'd1, "R10", "zero-count status", rd, 32'd1);
      idle(10);
      chk(rec_idx == 0, "R10", "zero-count words", 32'(rec_idx), 32'd0);
      reg_write(2'd0, 32'd0);

      // R4/R5: watermark pacing in memory-to-FIFO direction
      fifo_prog_empty = 1'b0; fifo_prog_full = 1'b1;
      prep(32'h0000_0200, 2, 1'b1, 1);
      reg_write(2'd0, 32'h8000_0001);
      idle(30);
      chk(rec_idx == 0 && !mem_req, "R4", "no request on wrong flag", 32'(rec_idx), 32'd0);
      reg_read(2'd3, rd);
      chk(rd == 32'd2, "R10", "busy and not done while waiting", rd, 32'd2);
      fifo_prog_empty = 1'b1;
      wait_words(1, 100);
      fifo_prog_empty = 1'b0;
      idle(200);
      chk(rec_idx == BLK, "R5", "one block per trigger", 32'(rec_idx), 32'(BLK));
      chk(done == 1'b0, "R10", "done low between blocks", {31'd0, done}, 32'd0);
      fifo_prog_empty = 1'b1;
      wait_done(400);
      chk(rec_idx == 2 * BLK, "R5", "second block words", 32'(rec_idx), 32'(2 * BLK));
      chk(done == 1'b1, "R10", "done after last block", {31'd0, done}, 32'd1);
      reg_write(2'd0, 32'd0);

      // sweep: direction x blocks x latency
      for (int d = 0; d < 2; d++) begin
         for (int n = 1; n <= 3; n++) begin
            for (int l = 0; l < 3; l++) begin
               fifo_prog_empty = (d == 1);
               fifo_prog_full  = (d == 0);
               prep(32'h0001_0000 + 32'(d * 9 + n * 3 + l) * 32'h400 + 32'(l), n, d[0], l);
               reg_write(2'd0, {1'b1, 30'd0, d[0]});
               idle(1);
               reg_read(2'd3, rd);
               chk(rd == 32'd2, "R10", "done cleared on start", rd, 32'd2);
               wait_done(n * BLK * 6 + 50);
               chk(done == 1'b1, "R10", "sweep done", {31'd0, done}, 32'd1);
               chk(rec_idx == n * BLK, "R5", "sweep word total", 32'(rec_idx), 32'(n * BLK));
               reg_write(2'd0, 32'd0);
               idle(2);
               reg_read(2'd3, rd);
               chk(rd == 32'd1, "R10", "done held after disable", rd, 32'd1);
            end
         end
      end

      // R3: register writes during a transfer do not disturb it
      fifo_prog_empty = 1'b0; fifo_prog_full = 1'b1;
      prep(32'h0000_8000, 2, 1'b0, 1);
      reg_write(2'd0, 32'h8000_0000);
      wait_words(3, 100);
      reg_write(2'd1, 32'h0000_4000);
      reg_write(2'd2, 32'h0000_0500);
      reg_write(2'd0, 32'h8000_0001);
      wait_done(400);
      chk(rec_idx == 2 * BLK, "R3", "latched count kept", 32'(rec_idx), 32'(2 * BLK));
      chk(done == 1'b1, "R3", "latched transfer done", {31'd0, done}, 32'd1);
      reg_write(2'd0, 32'd0);

      // R11: abort and restart
      fifo_prog_empty = 1'b1; fifo_prog_full = 1'b0;
      prep(32'h0000_2000, 3, 1'b1, 2);
      reg_write(2'd0, 32'h8000_0001);
      wait_words(5, 200);
      begin
         int k;
         k = rec_idx;
         reg_write(2'd0, 32'd0);
         idle(40);
         chk(rec_idx <= k + 2 && !mem_req, "R11", "stops after word in flight",
             32'(rec_idx), 32'(k + 2));
      end
      reg_read(2'd3, rd);
      chk(rd == 32'd0, "R11", "idle status after abort", rd, 32'd0);
      rec_idx = 0;
      reg_write(2'd0, 32'h8000_0001);
      wait_done(1000);
      chk(rec_idx == 3 * BLK, "R11", "restart word total", 32'(rec_idx), 32'(3 * BLK));
      chk(done == 1'b1, "R11", "restart done", {31'd0, done}, 32'd1);
      reg_write(2'd0, 32'd0);

      idle(5);
      finish_run();
   end
endmodule